// File: doc/BRIEF.md
# CMOS Configuration Register Bank

This block holds a 64-byte file of non-volatile configuration bytes that a host reaches through two byte-wide ports. A write to the index port picks a byte. Reads and writes on the data port then access that byte. Reset loads every byte from an image parameter.

The first data-port access after reset starts a small sequential engine. The engine adds one byte per clock over a fixed window of the file. It then stores the 16-bit total in two fixed slots, with the high byte going to the lower of the two indexes. While the engine runs, the block raises `stall` and holds the host's access. It performs that access once the total is stored. The engine never runs again until the next reset.

Top module: `cmos_bank`

## Requirements
- R1: A write to the index port (`port_sel`=0) keeps bits 6:0 of `wdata`. A read of the index port returns that stored index with bit 7 clear. The index resets to 0.
- R2: Data-port accesses (`port_sel`=1) use only bits 5:0 of the stored index, so indexes 0x40..0x7F reach the same bytes as 0x00..0x3F.
- R3: After reset, the byte at index i holds (29*i+7) mod 256, with these exceptions. Memory-size bytes hold 0x15=0x80 and 0x16=0x02 (base memory 0x0280), and 0x17=0x00 and 0x18=0x3B (extended memory 0x3B00). Checksum slots 0x2E and 0x2F hold 0x00.
- R4: The checksum is the 16-bit sum of bytes 0x10 through 0x2C inclusive. Its high byte is stored at 0x2E and its low byte at 0x2F.
- R5: The checksum is computed once per reset. Later writes to bytes in the summed window leave 0x2E and 0x2F unchanged.
- R6: `stall` is low out of reset. It rises at the clock edge that takes the first data-port strobe and stays high for exactly 32 cycles: 29 sum cycles, 2 store cycles and 1 cycle to perform the held access. It never rises again before the next reset.
- R7: The held first access is performed after the checksum is stored. A first write to a summed byte does not change the checksum. A first write to 0x2E replaces the stored high byte.
- R8: For every read strobe, `rdata` and `rdata_vld` update at the next clock edge, or at the edge that performs a held read. `rdata_vld` is high for that one cycle only. A data write is visible to the next data read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write value |
| rdata | output | 8 | Registered read result |
| rdata_vld | output | 1 | One-cycle pulse marking a new `rdata` |
| stall | output | 1 | High while the first data access is held for the checksum |

## Verification
The assertions take four things for granted about the host. It never raises both strobes in one cycle. It issues no strobe on either port while `stall` is high. Each strobe lasts a single cycle. The bench follows these rules: its access tasks pulse one strobe for one cycle, then wait on `stall` before returning. Scenarios that need a fresh checksum apply a new reset rather than relying on a second engine run.

// File: rtl/cmos_bank_pkg.sv
package cmos_bank_pkg;

  localparam int CMOS_DEPTH = 64;
  localparam int CMOS_DW    = 8;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SUM,
    ENG_STORE_HI,
    ENG_STORE_LO,
    ENG_DONE
  } eng_state_t;

  typedef struct packed {
    logic               is_wr;
    logic [CMOS_DW-1:0] data;
  } held_req_t;

  // Default power-on image: arithmetic fill, memory-size bytes, cleared checksum slots.
  function automatic logic [CMOS_DEPTH*CMOS_DW-1:0] cmos_reset_image();
    logic [CMOS_DEPTH*CMOS_DW-1:0] img;
    img = '0;
    for (int i = 0; i < CMOS_DEPTH; i++) begin
      logic [31:0] v;
      v = i * 29 + 7;
      img[i*CMOS_DW +: CMOS_DW] = v[CMOS_DW-1:0];
    end
    img[8'h15*CMOS_DW +: CMOS_DW] = 8'h80;
    img[8'h16*CMOS_DW +: CMOS_DW] = 8'h02;
    img[8'h17*CMOS_DW +: CMOS_DW] = 8'h00;
    img[8'h18*CMOS_DW +: CMOS_DW] = 8'h3B;
    img[8'h2E*CMOS_DW +: CMOS_DW] = 8'h00;
    img[8'h2F*CMOS_DW +: CMOS_DW] = 8'h00;
    return img;
  endfunction

  // One accumulation step of the checksum engine.
  function automatic logic [2*CMOS_DW-1:0] csum_step(
    input logic [2*CMOS_DW-1:0] acc,
    input logic [CMOS_DW-1:0]   b
  );
    return acc + {{CMOS_DW{1'b0}}, b};
  endfunction

endpackage

// File: rtl/cmos_index_reg.sv
module cmos_index_reg #(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DW-1:0]    din,
  output logic [IDX_W-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= din[IDX_W-1:0];
  end

endmodule

// File: rtl/cmos_byte_store.sv
module cmos_byte_store
  import cmos_bank_pkg::*;
#(
  parameter int DEPTH = CMOS_DEPTH,
  parameter int DW    = CMOS_DW,
  parameter logic [DEPTH*DW-1:0] IMAGE = cmos_reset_image(),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= IMAGE[i*DW +: DW];
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/cmos_csum_engine.sv
module cmos_csum_engine
  import cmos_bank_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int SUM_FIRST = 'h10,
  parameter int SUM_LAST  = 'h2C,
  parameter int HI_IDX    = 'h2E,
  parameter int LO_IDX    = 'h2F,
  localparam int CSW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] byte_in,
  output logic [AW-1:0] rd_addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          done
);

  localparam logic [AW-1:0] FIRST_A = AW'(SUM_FIRST);
  localparam logic [AW-1:0] LAST_A  = AW'(SUM_LAST);
  localparam logic [AW-1:0] HI_A    = AW'(HI_IDX);
  localparam logic [AW-1:0] LO_A    = AW'(LO_IDX);

  eng_state_t     state;
  logic [AW-1:0]  cursor;
  logic [CSW-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      cursor <= '0;
      acc    <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (start) begin
          state  <= ENG_SUM;
          cursor <= FIRST_A;
          acc    <= '0;
        end
        ENG_SUM: begin
          acc <= csum_step(acc, byte_in);
          if (cursor == LAST_A) state <= ENG_STORE_HI;
          else                  cursor <= cursor + 1'b1;
        end
        ENG_STORE_HI: state <= ENG_STORE_LO;
        ENG_STORE_LO: state <= ENG_DONE;
        default:      state <= ENG_DONE;
      endcase
    end
  end

  assign rd_addr = cursor;
  assign we      = (state == ENG_STORE_HI) || (state == ENG_STORE_LO);
  assign waddr   = (state == ENG_STORE_HI) ? HI_A : LO_A;
  assign wdata   = (state == ENG_STORE_HI) ? acc[CSW-1:DW] : acc[DW-1:0];
  assign done    = (state == ENG_DONE);

  // R4: the high byte is stored right after the last summed byte, then the low byte
  assert_sum_then_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_SUM && cursor == LAST_A) |=> (we && waddr == HI_A));
  assert_hi_then_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == HI_A) |=> (we && waddr == LO_A));
  // R4: the engine writes nowhere but the two checksum slots
  assert_engine_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr == HI_A || waddr == LO_A));
  // R5: once finished the engine stays finished
  assert_runs_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R4: the cursor never leaves the summed window while summing
  assert_cursor_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_SUM) |-> (cursor >= FIRST_A && cursor <= LAST_A));

endmodule

// File: rtl/cmos_bank.sv
module cmos_bank
  import cmos_bank_pkg::*;
#(
  parameter int DEPTH     = CMOS_DEPTH,
  parameter int DW        = CMOS_DW,
  parameter int IDX_W     = 7,
  parameter int SUM_FIRST = 'h10,
  parameter int SUM_LAST  = 'h2C,
  parameter int HI_IDX    = 'h2E,
  parameter int LO_IDX    = 'h2F,
  parameter logic [DEPTH*DW-1:0] IMAGE = cmos_reset_image()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic          port_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld,
  output logic          stall
);

  localparam int AW = $clog2(DEPTH);

  // Named internal events
  logic          idx_load, idx_read, data_req;
  logic          serve_held, host_rd_go, host_wr_go;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0] data_addr;
  logic [DW-1:0] host_wval;
  held_req_t     held_q;
  logic          held_vld_q;

  logic          eng_done, eng_we;
  logic [AW-1:0] eng_rd_addr, eng_waddr;
  logic [DW-1:0] eng_wdata, eng_byte;

  logic          st_we;
  logic [AW-1:0] st_waddr;
  logic [DW-1:0] st_wdata, st_rbyte;

  assign idx_load  = wr_stb & ~port_sel;
  assign idx_read  = rd_stb & ~port_sel;
  assign data_req  = (rd_stb | wr_stb) & port_sel;
  assign data_addr = idx[AW-1:0];

  cmos_index_reg #(.IDX_W(IDX_W), .DW(DW)) u_index (
    .clk(clk), .rst_n(rst_n), .load(idx_load), .din(wdata), .idx(idx)
  );

  // Holding register for the first data access while the checksum runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld_q <= 1'b0;
      held_q     <= '0;
    end else if (data_req && !eng_done) begin
      held_vld_q   <= 1'b1;
      held_q.is_wr <= wr_stb;
      held_q.data  <= wdata;
    end else if (serve_held) begin
      held_vld_q <= 1'b0;
    end
  end

  assign serve_held = held_vld_q & eng_done;
  assign host_rd_go = (rd_stb & port_sel & eng_done) | (serve_held & ~held_q.is_wr);
  assign host_wr_go = (wr_stb & port_sel & eng_done) | (serve_held & held_q.is_wr);
  assign host_wval  = serve_held ? held_q.data : wdata;
  assign stall      = held_vld_q;

  cmos_csum_engine #(
    .AW(AW), .DW(DW), .SUM_FIRST(SUM_FIRST), .SUM_LAST(SUM_LAST),
    .HI_IDX(HI_IDX), .LO_IDX(LO_IDX)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(data_req), .byte_in(eng_byte),
    .rd_addr(eng_rd_addr), .we(eng_we), .waddr(eng_waddr), .wdata(eng_wdata),
    .done(eng_done)
  );

  // Engine owns the write port until done; host writes only happen after
  assign st_we    = eng_we | host_wr_go;
  assign st_waddr = eng_we ? eng_waddr : data_addr;
  assign st_wdata = eng_we ? eng_wdata : host_wval;

  cmos_byte_store #(.DEPTH(DEPTH), .DW(DW), .IMAGE(IMAGE)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .raddr_a(eng_rd_addr), .rdata_a(eng_byte),
    .raddr_b(data_addr), .rdata_b(st_rbyte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= idx_read | host_rd_go;
      if (idx_read)        rdata <= DW'(idx);
      else if (host_rd_go) rdata <= st_rbyte;
    end
  end

  // R7: host writes reach the store only after the checksum is stored
  assert_host_write_after_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_go |-> (eng_done && !eng_we));
  // R6: once the engine is done and the held access served, stall never returns
  assert_no_second_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !stall) |=> !stall);
  // R6: no result is presented while the access is held
  assert_quiet_while_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !rdata_vld);
  // R8: a valid result always traces back to a read strobe or a served held access
  assert_vld_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld |-> ($past(rd_stb) || $past(stall)));
  // R1: an index read returns a value with bit 7 clear
  assert_index_read_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_read |=> (rdata[DW-1] == 1'b0 && rdata_vld));

endmodule

// File: tb/tb_cmos_bank.sv
`timescale 1ns/1ps
module tb_cmos_bank;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_stb, wr_stb, port_sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rdata_vld;
  logic       stall;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cmos_bank dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
    .rdata_vld(rdata_vld), .stall(stall)
  );

  // Bench model of the reset image (R3)
  function automatic logic [7:0] img_byte(input int i);
    case (i)
      'h15: return 8'h80;
      'h16: return 8'h02;
      'h17: return 8'h00;
      'h18: return 8'h3B;
      'h2E, 'h2F: return 8'h00;
      default: return 8'((i * 29 + 7) % 256);
    endcase
  endfunction

  function automatic logic [15:0] exp_sum();
    int s = 0;
    for (int i = 16; i <= 44; i++) s += int'(img_byte(i));
    return 16'(s);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic apply_reset();
    rd_stb = 0; wr_stb = 0; port_sel = 0; wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Pulse one strobe, then wait out any stall; returns stall length
  task automatic access(input bit is_wr, input bit sel, input logic [7:0] val,
                        output logic [7:0] got, output logic vld, output int stall_n);
    @(negedge clk);
    port_sel = sel; wdata = val;
    if (is_wr) wr_stb = 1; else rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
    stall_n = 0;
    while (stall) begin stall_n++; @(negedge clk); end
    got = rdata; vld = rdata_vld;
  endtask

  task automatic wr(input bit sel, input logic [7:0] val, output int stall_n);
    logic [7:0] g; logic v;
    access(1'b1, sel, val, g, v, stall_n);
  endtask

  task automatic rd(input bit sel, output logic [7:0] got, output logic vld, output int stall_n);
    access(1'b0, sel, 8'h00, got, vld, stall_n);
  endtask

  task automatic rd_byte(input logic [7:0] index, output logic [7:0] got);
    logic v; int n;
    wr(1'b0, index, n);
    rd(1'b1, got, v, n);
  endtask

  task automatic t_reset_state();
    logic [7:0] g; logic v; int n;
    apply_reset();
    check("R6 stall low after reset", int'(stall), 0);
    check("R8 rdata_vld low after reset", int'(rdata_vld), 0);
    rd(1'b0, g, v, n);
    check("R1 index resets to 0", int'(g), 0);
    check("R8 index read valid", int'(v), 1);
  endtask

  task automatic t_first_read();
    logic [7:0] g; logic v; int n;
    logic [15:0] s;
    s = exp_sum();
    wr(1'b0, 8'h2E, n);
    check("R6 index write not stalled", n, 0);
    rd(1'b1, g, v, n);
    check("R6 first data access stall length", n, 32);
    check("R4 checksum high byte at 0x2E", int'(g), int'(s[15:8]));
    check("R8 held read valid", int'(v), 1);
    @(negedge clk);
    check("R8 valid is one cycle", int'(rdata_vld), 0);
    wr(1'b0, 8'h2F, n);
    rd(1'b1, g, v, n);
    check("R6 no stall after first access", n, 0);
    check("R4 checksum low byte at 0x2F", int'(g), int'(s[7:0]));
    rd_byte(8'h15, g); check("R3 base mem low", int'(g), 'h80);
    rd_byte(8'h16, g); check("R3 base mem high", int'(g), 'h02);
    rd_byte(8'h17, g); check("R3 ext mem low", int'(g), 'h00);
    rd_byte(8'h18, g); check("R3 ext mem high", int'(g), 'h3B);
    rd_byte(8'h03, g); check("R3 fill byte 0x03", int'(g), int'(img_byte(3)));
    rd_byte(8'h3F, g); check("R3 fill byte 0x3F", int'(g), int'(img_byte('h3F)));
  endtask

  task automatic t_index_port();
    logic [7:0] g; logic v; int n;
    wr(1'b0, 8'hFF, n);
    rd(1'b0, g, v, n);
    check("R1 index keeps 7 bits (0xFF)", int'(g), 'h7F);
    wr(1'b0, 8'h93, n);
    rd(1'b0, g, v, n);
    check("R1 index keeps 7 bits (0x93)", int'(g), 'h13);
  endtask

  task automatic t_alias();
    logic [7:0] g; int n;
    rd_byte(8'h55, g);
    check("R2 index 0x55 aliases 0x15", int'(g), 'h80);
    wr(1'b0, 8'h70, n);
    wr(1'b1, 8'hC3, n);
    rd_byte(8'h30, g);
    check("R2 write via 0x70 lands at 0x30", int'(g), 'hC3);
  endtask

  task automatic t_no_recompute();
    logic [7:0] g; int n;
    logic [15:0] s;
    s = exp_sum();
    wr(1'b0, 8'h12, n);
    wr(1'b1, 8'hEE, n);
    check("R5 no stall on later write", n, 0);
    rd_byte(8'h12, g); check("R8 write visible to next read", int'(g), 'hEE);
    rd_byte(8'h2E, g); check("R5 high byte unchanged", int'(g), int'(s[15:8]));
    rd_byte(8'h2F, g); check("R5 low byte unchanged", int'(g), int'(s[7:0]));
  endtask

  task automatic t_held_write_in_window();
    logic [7:0] g; int n;
    logic [15:0] s;
    s = exp_sum();
    apply_reset();
    wr(1'b0, 8'h20, n);
    wr(1'b1, 8'hAA, n);
    check("R6 held write stall length", n, 32);
    rd_byte(8'h2F, g); check("R7 sum uses reset image", int'(g), int'(s[7:0]));
    rd_byte(8'h2E, g); check("R7 sum high uses reset image", int'(g), int'(s[15:8]));
    rd_byte(8'h20, g); check("R7 held write applied", int'(g), 'hAA);
  endtask

  task automatic t_held_write_slot();
    logic [7:0] g; int n;
    logic [15:0] s;
    s = exp_sum();
    apply_reset();
    wr(1'b0, 8'h2E, n);
    wr(1'b1, 8'h5A, n);
    check("R6 stall length second reset", n, 32);
    rd_byte(8'h2E, g); check("R7 held write overrides high slot", int'(g), 'h5A);
    rd_byte(8'h2F, g); check("R7 low slot keeps checksum", int'(g), int'(s[7:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_first_read();
    t_index_port();
    t_alias();
    t_no_recompute();
    t_held_write_in_window();
    t_held_write_slot();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule